// File: doc/BRIEF.md
# Timer Status Flags with Update-Event Qualifier

This block holds the sticky status flags of a general-purpose timer. It also decides whether an update flag is warranted. A counter core feeds it raw single-cycle strobes: overflow, underflow, software update request, counter reset by trigger, trigger edge, commutation, index, index error and encoder transition error. It also receives level signals: the repetition-counter-zero indication, the counter-running level used in gated slave mode, the encoder direction bit and the break inputs. The block qualifies these inputs and sets the matching flags. The flags stay set until software clears them.

Software reaches the block through a small register port. Address 0 is the flag register. Writing 0 to a bit clears that flag, and writing 1 leaves it alone. Address 1 holds the interrupt enable mask. A registered interrupt line is the OR of all enabled flags. A PWM permission output stays low while the system-break flag is set.

Top module: `tmr_evt_flags`

## Requirements
- R1: Overflow or underflow sets the update flag (bit 0) only when the repetition-zero input is high and update-disable is low. The update-source control has no effect on this path.
- R2: A software update request sets the update flag only when update-disable and update-source are both low.
- R3: A counter reset by trigger sets the update flag only when update-disable and update-source are both low.
- R4: Each break flag is set in the cycle after its break input is high. Bit 7 is system break, bit 8 is break 1 and bit 9 is break 2. A clear of that flag is ignored while its input stays high.
- R5: `pwm_permit` is low whenever the system-break flag (bit 7) is set, and high otherwise.
- R6: When gated mode is low, a trigger edge sets the trigger flag (bit 1). When gated mode is high, a change of the counter-running level sets the trigger flag, and trigger edges are ignored.
- R7: Any change in the value of the encoder direction input sets the direction flag (bit 4).
- R8: Commutation, index, index error and transition error set bits 2, 3, 5 and 6. Writing address 0 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R9: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R10: `irq` is high one cycle after any flag is set together with its enable bit at address 1, using the same bit positions. `irq` is low one cycle after no enabled flag remains.
- R11: Reset clears all flags and all enables, drives `irq` low and drives `pwm_permit` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ovf | input | 1 | Counter overflow strobe |
| ev_unf | input | 1 | Counter underflow strobe |
| rep_zero | input | 1 | Repetition counter is zero |
| sw_upd_req | input | 1 | Software reinitialisation request strobe |
| trg_reset | input | 1 | Counter reset by trigger strobe |
| ctl_upd_dis | input | 1 | Update disable control |
| ctl_upd_src | input | 1 | Update source control (1 = only overflow or underflow) |
| gated_mode | input | 1 | Slave controller is in gated mode |
| cnt_run | input | 1 | Counter running level |
| trg_edge | input | 1 | Active trigger edge strobe |
| ev_com | input | 1 | Commutation strobe |
| ev_idx | input | 1 | Index strobe |
| enc_dir | input | 1 | Encoder direction level |
| ev_idx_err | input | 1 | Index error strobe |
| ev_trans_err | input | 1 | Encoder transition error strobe |
| brk_in | input | BRK_CNT | Break input levels, bit 0 is system break |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = flags, 1 = interrupt enables |
| reg_wdata | input | 7+BRK_CNT | Write data |
| reg_rdata | output | 7+BRK_CNT | Read data of the addressed register |
| irq | output | 1 | Registered combined interrupt |
| pwm_permit | output | 1 | PWM restart permitted |

## Verification
The bench builds the block with the default BRK_CNT of 3. With three break channels, the system-break flag, both ordinary break flags, the PWM permission output and the full 10-bit flag word are all within reach. A table drives every combination of update cause and the two update controls that matters. Directed sequences then cover break hold-off, gated and edge trigger modes, direction toggles, set-versus-clear collisions, interrupt latency and a mid-run reset.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int unsigned FIX_FLAGS = 7;
  localparam int unsigned B_UPD  = 0;
  localparam int unsigned B_TRG  = 1;
  localparam int unsigned B_COM  = 2;
  localparam int unsigned B_IDX  = 3;
  localparam int unsigned B_DIR  = 4;
  localparam int unsigned B_IERR = 5;
  localparam int unsigned B_TERR = 6;
  localparam int unsigned B_BRK0 = 7;

  // Update qualification: counter wrap path and request/trigger path.
  function automatic logic f_upd_qualify(input logic ovf, input logic unf,
                                         input logic rep0, input logic req,
                                         input logic trst, input logic dis,
                                         input logic src);
    logic wrap_ok, req_ok;
    wrap_ok = (ovf | unf) & rep0 & ~dis;
    req_ok  = (req | trst) & ~dis & ~src;
    return wrap_ok | req_ok;
  endfunction

  // Trigger flag source chosen by slave mode.
  function automatic logic f_trg_set(input logic gated, input logic run_now,
                                     input logic run_prev, input logic edge_in);
    return gated ? (run_now ^ run_prev) : edge_in;
  endfunction
endpackage

// File: rtl/tmr_evt_decode.sv
module tmr_evt_decode
  import tmr_evt_pkg::*;
#(
  parameter int unsigned BRK_CNT = 3,
  localparam int unsigned NF = FIX_FLAGS + BRK_CNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_ovf,
  input  logic               ev_unf,
  input  logic               rep_zero,
  input  logic               sw_upd_req,
  input  logic               trg_reset,
  input  logic               ctl_upd_dis,
  input  logic               ctl_upd_src,
  input  logic               gated_mode,
  input  logic               cnt_run,
  input  logic               trg_edge,
  input  logic               ev_com,
  input  logic               ev_idx,
  input  logic               enc_dir,
  input  logic               ev_idx_err,
  input  logic               ev_trans_err,
  input  logic [BRK_CNT-1:0] brk_in,
  output logic [NF-1:0]      set_vec
);
  logic run_q, dir_q;
  logic upd_ok, trg_ok, dir_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      run_q <= cnt_run;
      dir_q <= enc_dir;
    end
  end

  assign upd_ok  = f_upd_qualify(ev_ovf, ev_unf, rep_zero, sw_upd_req,
                                 trg_reset, ctl_upd_dis, ctl_upd_src);
  assign trg_ok  = f_trg_set(gated_mode, cnt_run, run_q, trg_edge);
  assign dir_chg = enc_dir ^ dir_q;

  always_comb begin
    set_vec         = '0;
    set_vec[B_UPD]  = upd_ok;
    set_vec[B_TRG]  = trg_ok;
    set_vec[B_COM]  = ev_com;
    set_vec[B_IDX]  = ev_idx;
    set_vec[B_DIR]  = dir_chg;
    set_vec[B_IERR] = ev_idx_err;
    set_vec[B_TERR] = ev_trans_err;
    set_vec[NF-1:B_BRK0] = brk_in;
  end

  // R2, R3: update-source high blocks request and trigger-reset paths
  a_r2_src_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_upd_src && !ev_ovf && !ev_unf) |-> !upd_ok);
endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hw_set) flag_q <= 1'b1;
    else if (sw_clr) flag_q <= 1'b0;
  end

  // R9: a set in the same cycle as a clear leaves the flag high
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_q);
  // R8: a clear with no set drops the flag
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_set) |=> !flag_q);
endmodule

// File: rtl/tmr_irq_reg.sv
module tmr_irq_reg #(
  parameter int unsigned NF = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flags,
  input  logic [NF-1:0] enables,
  output logic          irq
);
  logic pend;
  assign pend = |(flags & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pend;
  end

  // R10: an enabled pending flag raises irq one cycle later
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq);
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
#(
  parameter int unsigned BRK_CNT = 3,
  localparam int unsigned NF = FIX_FLAGS + BRK_CNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_ovf,
  input  logic               ev_unf,
  input  logic               rep_zero,
  input  logic               sw_upd_req,
  input  logic               trg_reset,
  input  logic               ctl_upd_dis,
  input  logic               ctl_upd_src,
  input  logic               gated_mode,
  input  logic               cnt_run,
  input  logic               trg_edge,
  input  logic               ev_com,
  input  logic               ev_idx,
  input  logic               enc_dir,
  input  logic               ev_idx_err,
  input  logic               ev_trans_err,
  input  logic [BRK_CNT-1:0] brk_in,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [NF-1:0]      reg_wdata,
  output logic [NF-1:0]      reg_rdata,
  output logic               irq,
  output logic               pwm_permit
);
  logic [NF-1:0] set_vec, clr_vec, flag_q, en_q;
  logic          flag_wr, en_wr;

  assign flag_wr = reg_wr & ~reg_addr;
  assign en_wr   = reg_wr &  reg_addr;
  assign clr_vec = {NF{flag_wr}} & ~reg_wdata;

  tmr_evt_decode #(.BRK_CNT(BRK_CNT)) dec_i (
    .clk(clk), .rst_n(rst_n), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
    .rep_zero(rep_zero), .sw_upd_req(sw_upd_req), .trg_reset(trg_reset),
    .ctl_upd_dis(ctl_upd_dis), .ctl_upd_src(ctl_upd_src),
    .gated_mode(gated_mode), .cnt_run(cnt_run), .trg_edge(trg_edge),
    .ev_com(ev_com), .ev_idx(ev_idx), .enc_dir(enc_dir),
    .ev_idx_err(ev_idx_err), .ev_trans_err(ev_trans_err),
    .brk_in(brk_in), .set_vec(set_vec)
  );

  for (genvar g = 0; g < NF; g++) begin : g_flag
    tmr_flag_bit fb_i (
      .clk(clk), .rst_n(rst_n), .hw_set(set_vec[g]),
      .sw_clr(clr_vec[g]), .flag_q(flag_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata;
  end

  tmr_irq_reg #(.NF(NF)) irq_i (
    .clk(clk), .rst_n(rst_n), .flags(flag_q), .enables(en_q), .irq(irq)
  );

  assign reg_rdata  = reg_addr ? en_q : flag_q;
  assign pwm_permit = ~flag_q[B_BRK0];

  // R1: with updates disabled a clear update flag stays clear
  a_r1_dis_blocks_update: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[B_UPD] && ctl_upd_dis) |=> !flag_q[B_UPD]);
  // R5: an active system break withdraws PWM permission next cycle
  a_r5_sysbrk_permit: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in[0] |=> !pwm_permit);

  for (genvar b = 0; b < BRK_CNT; b++) begin : g_brk_chk
    // R4: break flag holds while its input is active, even under a clear
    a_r4_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      brk_in[b] |=> flag_q[B_BRK0+b]);
  end
endmodule

// File: tb/tmr_evt_flags_tb_top.sv
module tmr_evt_flags_tb_top;
  localparam int NF = 10;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_ovf, ev_unf, rep_zero, sw_upd_req, trg_reset, ctl_upd_dis, ctl_upd_src;
  logic gated_mode, cnt_run, trg_edge, ev_com, ev_idx, enc_dir, ev_idx_err, ev_trans_err;
  logic [2:0] brk_in;
  logic reg_wr, reg_addr;
  logic [NF-1:0] reg_wdata, reg_rdata;
  logic irq, pwm_permit;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // vector bits: [7]ovf [6]unf [5]rep0 [4]req [3]trst [2]dis [1]src [0]expected
  localparam logic [7:0] VEC [12] = '{
    8'b1010_0001, 8'b1000_0000, 8'b0110_0001, 8'b0110_0100,
    8'b1010_0011, 8'b0001_0001, 8'b0001_0010, 8'b0001_0100,
    8'b0000_1001, 8'b0000_1010, 8'b0000_1100, 8'b0010_0000
  };

  always #2 clk = ~clk;

  tmr_evt_flags dut_i (
    .clk(clk), .rst_n(rst_n), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
    .rep_zero(rep_zero), .sw_upd_req(sw_upd_req), .trg_reset(trg_reset),
    .ctl_upd_dis(ctl_upd_dis), .ctl_upd_src(ctl_upd_src),
    .gated_mode(gated_mode), .cnt_run(cnt_run), .trg_edge(trg_edge),
    .ev_com(ev_com), .ev_idx(ev_idx), .enc_dir(enc_dir),
    .ev_idx_err(ev_idx_err), .ev_trans_err(ev_trans_err), .brk_in(brk_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .pwm_permit(pwm_permit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic a, input logic [NF-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {ev_ovf, ev_unf, rep_zero, sw_upd_req, trg_reset, ctl_upd_dis, ctl_upd_src} = '0;
    {gated_mode, cnt_run, trg_edge, ev_com, ev_idx, enc_dir, ev_idx_err, ev_trans_err} = '0;
    brk_in = '0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R11: reset state
    chk("R11 flags", reg_rdata, 0);
    chk("R11 irq", irq, 0);
    chk("R11 permit", pwm_permit, 1);
    reg_addr = 1'b1; #0.5; chk("R11 enables", reg_rdata, 0); reg_addr = 1'b0;

    // R1, R2, R3: update qualification table
    foreach (VEC[i]) begin
      wr(1'b0, '0);
      {ev_ovf, ev_unf, rep_zero, sw_upd_req, trg_reset, ctl_upd_dis, ctl_upd_src} = VEC[i][7:1];
      step();
      {ev_ovf, ev_unf, rep_zero, sw_upd_req, trg_reset, ctl_upd_dis, ctl_upd_src} = '0;
      chk($sformatf("R1/R2/R3 update vector %0d", i), reg_rdata[0], VEC[i][0]);
    end
    wr(1'b0, '0);

    // R4: break 1 flag held while input active
    brk_in = 3'b010; step();
    chk("R4 break1 set", reg_rdata[8], 1);
    wr(1'b0, ~(10'd1 << 8));
    chk("R4 clear ignored while active", reg_rdata[8], 1);
    brk_in = '0; step();
    wr(1'b0, ~(10'd1 << 8));
    chk("R4 clear after release", reg_rdata[8], 0);

    // R5: system break withholds permission until cleared
    brk_in = 3'b001; step();
    chk("R5 permit low on sys break", pwm_permit, 0);
    brk_in = '0; step();
    chk("R5 permit stays low while flag set", pwm_permit, 0);
    wr(1'b0, ~(10'd1 << 7));
    chk("R5 permit back after clear", pwm_permit, 1);

    // R6: trigger flag modes
    trg_edge = 1'b1; step(); trg_edge = 1'b0;
    chk("R6 edge mode sets", reg_rdata[1], 1);
    wr(1'b0, '0);
    gated_mode = 1'b1; cnt_run = 1'b1; step();
    chk("R6 gated start sets", reg_rdata[1], 1);
    wr(1'b0, '0);
    trg_edge = 1'b1; step(); trg_edge = 1'b0;
    chk("R6 gated edge ignored", reg_rdata[1], 0);
    cnt_run = 1'b0; step();
    chk("R6 gated stop sets", reg_rdata[1], 1);
    gated_mode = 1'b0; wr(1'b0, '0);

    // R7: direction change
    enc_dir = 1'b1; step();
    chk("R7 dir rise", reg_rdata[4], 1);
    wr(1'b0, '0); step();
    chk("R7 steady dir no set", reg_rdata[4], 0);
    enc_dir = 1'b0; step();
    chk("R7 dir fall", reg_rdata[4], 1);
    wr(1'b0, '0);

    // R8: strobe flags, write 0 clears, write 1 keeps
    ev_com = 1'b1; ev_idx = 1'b1; ev_idx_err = 1'b1; ev_trans_err = 1'b1; step();
    ev_com = 1'b0; ev_idx = 1'b0; ev_idx_err = 1'b0; ev_trans_err = 1'b0;
    chk("R8 strobes set", reg_rdata, 10'b00_0110_1100);
    wr(1'b0, ~10'b00_0100_1000);
    chk("R8 selective clear", reg_rdata, 10'b00_0010_0100);

    // R9: set beats clear in the same cycle
    ev_com = 1'b1; wr(1'b0, '0); ev_com = 1'b0;
    chk("R9 set wins", reg_rdata, 10'b00_0000_0100);
    wr(1'b0, '0);

    // R10: interrupt masking and latency
    wr(1'b1, 10'b00_0000_0100);
    ev_idx = 1'b1; step(); ev_idx = 1'b0;
    step();
    chk("R10 masked flag no irq", irq, 0);
    ev_com = 1'b1; step(); ev_com = 1'b0;
    chk("R10 irq one cycle late", irq, 0);
    step();
    chk("R10 irq raised", irq, 1);
    wr(1'b0, '0); step();
    chk("R10 irq drops", irq, 0);

    // R11: mid-run reset
    ev_com = 1'b1; brk_in = 3'b100; step(); ev_com = 1'b0; brk_in = '0;
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R11 reset clears flags", reg_rdata, 0);
    chk("R11 reset irq", irq, 0);

    finish_run();
  end
endmodule